// File: doc/BRIEF.md
# Configuration Port Unlock Front End

This block sits behind a byte-wide I/O strobe bus and exposes a bank of 8-bit configuration registers through two adjacent I/O addresses. The lower address is an index port and the address one above it is a data port. A strap input chooses which of two base addresses the pair responds at. Nothing behind the ports can be reached until a two-byte key arrives on the index port. Once the block is open, an index write selects a register, and data-port reads and writes reach that register. A specific byte written to the index port closes the block again.

A few global registers sit below index 0x30. They hold a read-only identification byte, a read-only revision byte, the strap reflected as a status bit, and a logical-device selector. Registers at 0x30 and above are banked. Each logical device has its own copy, and only the copy named by the selector is visible. The block drives the current selector, the per-device activation bits and same-cycle register access strobes out to the function blocks behind it.

The key detector has three states. **LOCKED** is entered at reset. **KEY_HALF** is entered from LOCKED when 0x87 is written to the index port. **OPEN** is entered from KEY_HALF when a second consecutive 0x87 is written to the index port. KEY_HALF falls back to LOCKED on any other write to either port. OPEN returns to LOCKED when 0xAA is written to the index port. Reads never move the state.

Top module: `cfg_port_unlock`

## Requirements
- R1: The index port sits at base and the data port at base+1. Base is 0x2E when `strap_hibase`=0 and 0x4E when it is 1. Reads of any other address return 0xFF, and writes to any other address change nothing.
- R2: After reset the block is LOCKED (`cfg_unlocked`=0). While LOCKED, reads of either port return 0xFF. Data writes and index writes other than 0x87 are ignored.
- R3: Two consecutive index writes of 0x87 open the block. Any other write to either port between the two key bytes returns the detector to LOCKED.
- R4: An index write of 0xAA while OPEN returns to LOCKED and clears the index register to 0x00.
- R5: While OPEN, an index write stores the byte as the register index, and an index-port read returns it. The index is 0x00 after reset.
- R6: Index 0x20 reads the DEV_ID parameter and index 0x21 reads DEV_REV. Both are read-only.
- R7: Index 0x26 reads the strap in bit 6, with all other bits 0. It is read-only.
- R8: Index 0x07 is a read/write logical-device selector, reset 0x00, driven on `ld_sel`. It cannot change while LOCKED.
- R9: For a selector below NUM_LDEV, index 0x30 holds that device's activation bit in bit 0. It reads back as {7'b0, bit}, and the bit appears on `ld_active[selector]`. Indices 0xF0 to 0xF0+NREG-1 are read/write bytes private to that device. All of these reset to 0.
- R10: With a selector of NUM_LDEV or above, registers at 0x30 and above read 0x00 and writes to them are ignored. Every unimplemented index reads 0x00.
- R11: `reg_wr_stb` or `reg_rd_stb` is high in the same cycle as a data-port write or read while OPEN. In that cycle `reg_idx` carries the index and `reg_wdata` the write byte. Neither strobe is ever high while not OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_hibase | input | 1 | Base select: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | AW | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational from address and state |
| cfg_unlocked | output | 1 | High in the OPEN state |
| ld_sel | output | 8 | Current logical-device selector |
| ld_active | output | NUM_LDEV | Activation bit of each logical device |
| reg_wr_stb | output | 1 | Register write strobe for downstream blocks |
| reg_rd_stb | output | 1 | Register read strobe for downstream blocks |
| reg_idx | output | 8 | Selected register index |
| reg_wdata | output | 8 | Register write byte |

## Verification
The bench sweeps every index byte other than 0x87 between two key bytes. A detector that did not restart on an interruption would open on one of them. A data-port write is also placed between the key bytes, which catches a detector that watches only the index port. Every index value is written and read back against an arithmetic model of the global map, so a mis-decoded ID, revision, strap or hole shows up as a wrong byte. Every logical device is filled with a distinct pattern and read back, which exposes any bank aliasing. Out-of-range selectors, key bytes sent to the wrong base, and the clearing of the index on exit are each probed, because a design that got them wrong would leak writes, open at the wrong address, or come back pointing at a stale register.

// File: rtl/cfg_unlock_pkg.sv
`timescale 1ns/1ps
package cfg_unlock_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_HALF = 2'd1,
        ST_OPEN     = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_ENTER     = 8'h87;
    localparam logic [7:0] KEY_EXIT      = 8'hAA;
    localparam logic [7:0] IDX_LDN       = 8'h07;
    localparam logic [7:0] IDX_DEVID     = 8'h20;
    localparam logic [7:0] IDX_DEVREV    = 8'h21;
    localparam logic [7:0] IDX_STRAP     = 8'h26;
    localparam logic [7:0] IDX_BANK_LO   = 8'h30;
    localparam logic [7:0] IDX_ACTIVE    = 8'h30;
    localparam int         IDX_BYTES     = 'hF0;
    localparam int         STRAP_BIT     = 6;
    localparam logic [7:0] RD_IDLE       = 8'hFF;
endpackage

// File: rtl/cfg_port_decode.sv
`timescale 1ns/1ps
module cfg_port_decode #(
    parameter int            AW      = 16,
    parameter logic [AW-1:0] BASE_LO = 16'h002E,
    parameter logic [AW-1:0] BASE_HI = 16'h004E
) (
    input  logic [AW-1:0] addr,
    input  logic          strap_hi,
    output logic          hit_idx,
    output logic          hit_data
);
    logic [AW-1:0] base;

    assign base     = strap_hi ? BASE_HI : BASE_LO;
    assign hit_idx  = (addr == base);
    assign hit_data = (addr == base + AW'(1));
endmodule

// File: rtl/cfg_key_fsm.sv
`timescale 1ns/1ps
module cfg_key_fsm
    import cfg_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic       open_o,
    output logic       exit_o
);
    key_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_ENTER) state_d = ST_KEY_HALF;
            end
            ST_KEY_HALF: begin
                if (idx_wr && wdata == KEY_ENTER) state_d = ST_OPEN;
                else if (idx_wr || data_wr)       state_d = ST_LOCKED;
            end
            ST_OPEN: begin
                if (idx_wr && wdata == KEY_EXIT)  state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        open_o = (state_q == ST_OPEN);
        exit_o = (state_q == ST_OPEN) && idx_wr && (wdata == KEY_EXIT);
    end
endmodule

// File: rtl/cfg_ldev_bank.sv
`timescale 1ns/1ps
module cfg_ldev_bank
    import cfg_unlock_pkg::*;
#(
    parameter int NUM_LDEV = 10,
    parameter int NREG     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          ldn,
    input  logic                wr_en,
    input  logic [7:0]          idx,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic [NUM_LDEV-1:0] active
);
    localparam int RDW = NUM_LDEV * 8;

    logic [RDW-1:0] rd_bus;

    for (genvar g = 0; g < NUM_LDEV; g++) begin : g_dev
        logic       act_q;
        logic [7:0] mem_q [NREG];
        logic [7:0] rd_b;
        logic       sel;

        assign sel = (ldn == 8'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q <= 1'b0;
                for (int r = 0; r < NREG; r++) mem_q[r] <= 8'h00;
            end else if (wr_en && sel) begin
                if (idx == IDX_ACTIVE) act_q <= wdata[0];
                for (int r = 0; r < NREG; r++) begin
                    if (idx == 8'(IDX_BYTES + r)) mem_q[r] <= wdata;
                end
            end
        end

        always_comb begin
            rd_b = 8'h00;
            if (idx == IDX_ACTIVE) rd_b = {7'b0, act_q};
            for (int r = 0; r < NREG; r++) begin
                if (idx == 8'(IDX_BYTES + r)) rd_b = mem_q[r];
            end
        end

        assign rd_bus[g*8 +: 8] = rd_b;
        assign active[g]        = act_q;
    end

    always_comb begin
        rdata = 8'h00;
        for (int g = 0; g < NUM_LDEV; g++) begin
            if (ldn == 8'(g)) rdata = rd_bus[g*8 +: 8];
        end
    end
endmodule

// File: rtl/cfg_port_unlock.sv
`timescale 1ns/1ps
module cfg_port_unlock
    import cfg_unlock_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] BASE_LO  = 16'h002E,
    parameter logic [AW-1:0] BASE_HI  = 16'h004E,
    parameter logic [7:0]    DEV_ID   = 8'hA0,
    parameter logic [7:0]    DEV_REV  = 8'h25,
    parameter int            NUM_LDEV = 10,
    parameter int            NREG     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_hibase,
    input  logic [AW-1:0]       io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    output logic                cfg_unlocked,
    output logic [7:0]          ld_sel,
    output logic [NUM_LDEV-1:0] ld_active,
    output logic                reg_wr_stb,
    output logic                reg_rd_stb,
    output logic [7:0]          reg_idx,
    output logic [7:0]          reg_wdata
);
    logic       hit_idx, hit_data;
    logic       idx_wr, data_wr;
    logic       open, exit_evt;
    logic       cfg_wr;
    logic [7:0] idx_q, ldn_q;
    logic [7:0] bank_rd;
    logic [7:0] reg_rd;

    cfg_port_decode #(
        .AW(AW), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
    ) u_dec (
        .addr(io_addr), .strap_hi(strap_hibase),
        .hit_idx(hit_idx), .hit_data(hit_data)
    );

    assign idx_wr  = hit_idx  & io_wr;
    assign data_wr = hit_data & io_wr;

    cfg_key_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .idx_wr(idx_wr), .data_wr(data_wr), .wdata(io_wdata),
        .open_o(open), .exit_o(exit_evt)
    );

    assign cfg_wr = open & data_wr;

    always_ff @(posedge clk) begin
        if (!rst_n)              idx_q <= 8'h00;
        else if (exit_evt)       idx_q <= 8'h00;
        else if (open && idx_wr) idx_q <= io_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           ldn_q <= 8'h00;
        else if (cfg_wr && idx_q == IDX_LDN)  ldn_q <= io_wdata;
    end

    cfg_ldev_bank #(
        .NUM_LDEV(NUM_LDEV), .NREG(NREG)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .ldn(ldn_q),
        .wr_en(cfg_wr && (idx_q >= IDX_BANK_LO)),
        .idx(idx_q), .wdata(io_wdata),
        .rdata(bank_rd), .active(ld_active)
    );

    always_comb begin
        unique case (idx_q)
            IDX_LDN:    reg_rd = ldn_q;
            IDX_DEVID:  reg_rd = DEV_ID;
            IDX_DEVREV: reg_rd = DEV_REV;
            IDX_STRAP:  reg_rd = 8'(strap_hibase) << STRAP_BIT;
            default:    reg_rd = (idx_q >= IDX_BANK_LO) ? bank_rd : 8'h00;
        endcase
    end

    always_comb begin
        io_rdata = RD_IDLE;
        if (open && hit_idx)  io_rdata = idx_q;
        if (open && hit_data) io_rdata = reg_rd;
    end

    assign cfg_unlocked = open;
    assign ld_sel       = ldn_q;
    assign reg_wr_stb   = cfg_wr;
    assign reg_rd_stb   = open & hit_data & io_rd;
    assign reg_idx      = idx_q;
    assign reg_wdata    = io_wdata;
endmodule

// File: rtl/cfg_unlock_checker.sv
`timescale 1ns/1ps
module cfg_unlock_checker #(
    parameter int            AW      = 16,
    parameter logic [AW-1:0] BASE_LO = 16'h002E,
    parameter logic [AW-1:0] BASE_HI = 16'h004E
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strap_hibase,
    input logic [AW-1:0] io_addr,
    input logic          io_wr,
    input logic          io_rd,
    input logic [7:0]    io_wdata,
    input logic [7:0]    io_rdata,
    input logic          cfg_unlocked,
    input logic [7:0]    ld_sel,
    input logic          reg_wr_stb,
    input logic          reg_rd_stb
);
    logic a_idx, a_data;
    always_comb begin
        a_idx  = io_addr == (strap_hibase ? BASE_HI : BASE_LO);
        a_data = io_addr == ((strap_hibase ? BASE_HI : BASE_LO) + AW'(1));
    end

    assert_miss_reads_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !a_idx && !a_data) |-> io_rdata == 8'hFF);

    assert_locked_reads_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && io_rd && (a_idx || a_data)) |-> io_rdata == 8'hFF);

    assert_open_after_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_unlocked) |-> $past(io_wr && a_idx && io_wdata == 8'h87));

    assert_exit_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && io_wr && a_idx && io_wdata == 8'hAA) |=> !cfg_unlocked);

    assert_ldsel_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> $stable(ld_sel));

    assert_strobe_open_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_stb || reg_rd_stb) |-> cfg_unlocked);
endmodule

bind cfg_port_unlock cfg_unlock_checker #(
    .AW(AW), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
) i_chk (
    .clk(clk), .rst_n(rst_n), .strap_hibase(strap_hibase),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_unlocked(cfg_unlocked), .ld_sel(ld_sel),
    .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb)
);

// File: tb/test_cfg_port_unlock.sv
`timescale 1ns/1ps
module test_cfg_port_unlock;
    localparam int         NLD  = 10;
    localparam int         NR   = 8;
    localparam logic [7:0] ID   = 8'hA0;
    localparam logic [7:0] REV  = 8'h25;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            strap = 0;
    logic [15:0]     io_addr = 0;
    logic            io_wr = 0, io_rd = 0;
    logic [7:0]      io_wdata = 0;
    logic [7:0]      io_rdata;
    logic            cfg_unlocked;
    logic [7:0]      ld_sel;
    logic [NLD-1:0]  ld_active;
    logic            reg_wr_stb, reg_rd_stb;
    logic [7:0]      reg_idx, reg_wdata;

    int n_checks = 0, n_fail = 0;
    logic s_wr_stb, s_rd_stb;
    logic [7:0] s_idx, s_wdata;

    always #2.5 clk = ~clk;

    cfg_port_unlock i_cfg_port_unlock (
        .clk(clk), .rst_n(rst_n), .strap_hibase(strap),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_unlocked(cfg_unlocked), .ld_sel(ld_sel), .ld_active(ld_active),
        .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata)
    );

    function automatic logic [15:0] base_of(input logic s);
        return s ? 16'h004E : 16'h002E;
    endfunction

    function automatic logic [7:0] pat(input int ld, input int r);
        return 8'((ld * 37 + r * 11) ^ 'h5A);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1; io_rd = 0;
        #1;
        s_wr_stb = reg_wr_stb; s_idx = reg_idx; s_wdata = reg_wdata;
        @(posedge clk);
        #1 io_wr = 0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1; io_wr = 0;
        #1;
        d = io_rdata; s_rd_stb = reg_rd_stb; s_idx = reg_idx;
        @(posedge clk);
        #1 io_rd = 0;
    endtask

    task automatic unlock();
        bus_wr(base_of(strap), 8'h87);
        bus_wr(base_of(strap), 8'h87);
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        bus_wr(base_of(strap), idx);
        bus_wr(base_of(strap) + 16'd1, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        bus_wr(base_of(strap), idx);
        bus_rd(base_of(strap) + 16'd1, d);
    endtask

    function automatic logic [7:0] global_exp(input int v);
        case (v)
            'h20: return ID;
            'h21: return REV;
            'h26: return 8'(strap) << 6;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R2: reset state
        check("R2 reset locked", cfg_unlocked, 0);
        check("R8 reset ld_sel", ld_sel, 0);
        bus_rd(16'h002F, d);
        check("R2 locked data read", d, 'hFF);
        bus_rd(16'h002E, d);
        check("R2 locked index read", d, 'hFF);

        // R2 / R11: locked writes ignored, no strobes
        bus_wr(16'h002F, 8'h55);
        check("R11 no wr strobe locked", s_wr_stb, 0);
        bus_wr(16'h002E, 8'h20);
        check("R2 stays locked", cfg_unlocked, 0);

        // R3: interrupted key never opens
        for (int v = 0; v < 256; v++) begin
            if (v != 'h87) begin
                bus_wr(16'h002E, 8'h87);
                bus_wr(16'h002E, 8'(v));
                bus_wr(16'h002E, 8'h87);
                check("R3 interrupted key", cfg_unlocked, 0);
                bus_wr(16'h002E, 8'h00);
            end
        end
        bus_wr(16'h002E, 8'h87);
        bus_wr(16'h002F, 8'h87);
        bus_wr(16'h002E, 8'h87);
        check("R3 data write between keys", cfg_unlocked, 0);
        bus_wr(16'h002E, 8'h00);

        // R1: key at the wrong base
        bus_wr(16'h004E, 8'h87);
        bus_wr(16'h004E, 8'h87);
        check("R1 wrong base key", cfg_unlocked, 0);

        // R3: proper key opens
        unlock();
        check("R3 key opens", cfg_unlocked, 1);
        bus_rd(16'h002E, d);
        check("R5 index after locked writes", d, 0);
        bus_rd(16'h0030, d);
        check("R1 miss address read", d, 'hFF);

        // R5/R6/R7/R10: index sweep and global map
        for (int v = 0; v < 256; v++) begin
            if (v != 'hAA) begin
                bus_wr(16'h002E, 8'(v));
                bus_rd(16'h002E, d);
                check("R5 index readback", d, v);
                bus_rd(16'h002F, d);
                check("R10 R6 R7 global map", d, global_exp(v));
            end
        end
        reg_write(8'h20, 8'h11);
        reg_read(8'h20, d);
        check("R6 id read-only", d, ID);
        reg_write(8'h21, 8'h11);
        reg_read(8'h21, d);
        check("R6 rev read-only", d, REV);
        reg_write(8'h26, 8'hFF);
        reg_read(8'h26, d);
        check("R7 strap read-only", d, 0);

        // R9: fill all banks
        for (int ld = 0; ld < NLD; ld++) begin
            reg_write(8'h07, 8'(ld));
            check("R8 ld_sel follows", ld_sel, ld);
            reg_write(8'h30, 8'(8'hFE | 8'(ld & 1)));
            for (int r = 0; r < NR; r++) reg_write(8'(8'hF0 + r), pat(ld, r));
        end
        check("R9 active vector", ld_active, 'h2AA);
        for (int ld = 0; ld < NLD; ld++) begin
            reg_write(8'h07, 8'(ld));
            reg_read(8'h07, d);
            check("R8 selector readback", d, ld);
            reg_read(8'h30, d);
            check("R9 active readback", d, ld & 1);
            for (int r = 0; r < NR; r++) begin
                reg_read(8'(8'hF0 + r), d);
                check("R9 bank byte", d, pat(ld, r));
            end
        end

        // R10: out-of-range selector
        reg_write(8'h07, 8'h0C);
        reg_write(8'h30, 8'h01);
        reg_write(8'hF0, 8'h77);
        reg_read(8'h30, d);
        check("R10 oor active read", d, 0);
        reg_read(8'hF0, d);
        check("R10 oor byte read", d, 0);
        check("R10 oor write ignored", ld_active, 'h2AA);
        reg_write(8'h07, 8'h03);
        reg_read(8'hF0, d);
        check("R10 bank 3 untouched", d, pat(3, 0));

        // R11: strobes
        reg_write(8'hF1, 8'h3C);
        check("R11 wr strobe", s_wr_stb, 1);
        check("R11 wr idx", s_idx, 'hF1);
        check("R11 wr data", s_wdata, 'h3C);
        reg_read(8'hF1, d);
        check("R11 rd strobe", s_rd_stb, 1);
        check("R11 rd idx", s_idx, 'hF1);

        // R4: exit
        bus_wr(16'h002E, 8'h21);
        bus_wr(16'h002E, 8'hAA);
        check("R4 exit locks", cfg_unlocked, 0);
        bus_rd(16'h002F, d);
        check("R2 data read after exit", d, 'hFF);
        check("R11 no rd strobe locked", s_rd_stb, 0);
        bus_wr(16'h002F, 8'h09);
        check("R11 no wr strobe after exit", s_wr_stb, 0);
        check("R8 ld_sel frozen", ld_sel, 3);
        unlock();
        bus_rd(16'h002E, d);
        check("R4 index cleared", d, 0);
        bus_wr(16'h002E, 8'hAA);

        // R1/R7: high base via strap
        strap = 1;
        bus_wr(16'h002E, 8'h87);
        bus_wr(16'h002E, 8'h87);
        check("R1 old base ignored", cfg_unlocked, 0);
        bus_wr(16'h002E, 8'h00);
        unlock();
        check("R1 high base opens", cfg_unlocked, 1);
        reg_read(8'h26, d);
        check("R7 strap bit", d, 'h40);
        bus_rd(16'h002F, d);
        check("R1 old data port miss", d, 'hFF);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule